// File: doc/BRIEF.md
# Two-Stage Ones-Counting Decimator

This block turns a single-bit oversampled delta-sigma stream into multi-bit unsigned samples at a much lower rate, using two decimation stages in series. The first stage takes the accepted input bits in back-to-back, non-overlapping windows of `WIN_LEN` bits (16 by default). For each window it produces the number of 1s seen, which stands for the density of 1s in that window. Its result rate is the accepted bit rate divided by the window length.

The second stage is a boxcar low-pass filter. It adds `AVG_LEN` consecutive window counts (4 by default) and produces one sum per group, so the rate drops again and the word grows. Input bits come with a qualifying strobe. Each output word comes with a one-cycle strobe and stays on the data port until the next result. A synchronous reset throws away any partial window and any partial group.

Top module: `dsd_bitcount_decimator`

## Requirements
- R1: While reset is high, and in the first cycle after it, `smp_vld` is 0 and `smp_data` is 0.
- R2: Stage one counts the 1s in each run of `WIN_LEN` accepted bits. A new window starts with the next accepted bit, and windows never overlap or share bits.
- R3: A bit presented with `bit_vld` low is not counted and does not advance the window position. Output results and their timing depend only on the sequence of accepted bits.
- R4: Each output equals the sum of `AVG_LEN` consecutive window counts. With the default `LEFT_ALIGN = 0` the sum sits in the low bits of `smp_data` and the upper bits are 0, so the range is 0 to `WIN_LEN*AVG_LEN` (0 to 64).
- R5: `smp_vld` is a single-cycle pulse. It is high in the cycle that starts two clock edges after the edge that accepted the last bit of a group.
- R6: `smp_data` keeps its value between pulses and changes only when `smp_vld` is high.
- R7: A reset in the middle of a window or group discards those bits. The first output after reset covers only `WIN_LEN*AVG_LEN` bits accepted after reset.
- R8: A group of all 1s gives 64 and a group of all 0s gives 0.
- R9: The 8-bit pattern 1,0,1,0,1,1,1,0 holds five 1s. Repeated over a group, it gives a count of 10 per 16-bit window and an output of 40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Modulator output bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit to accept |
| smp_data | output | OUT_W | Decimated unsigned sample, held between results |
| smp_vld | output | 1 | One-cycle pulse marking a new `smp_data` |

## Verification
A result is due two clock edges after the edge that accepted the closing bit of a group. One register is the stage-one window result and the other is the stage-two sum. The reference model in the bench records each expected result in a two-deep delay line when it drives the closing bit. It compares strobe and data against the head of that line at every falling edge, so an early, late or doubled pulse shows up in the exact cycle it happens. Reset clears the delay line in the same cycle as the design, so partial windows cut short by reset are checked with the same cycle alignment.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  // Width needed to hold the values 0..n inclusive.
  function automatic int unsigned span_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Width of an index that counts 0..n-1.
  function automatic int unsigned index_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dsd_window_counter.sv
module dsd_window_counter #(
  parameter int unsigned WIN_LEN = 16,
  parameter int unsigned CNT_W   = dsd_pkg::span_width(WIN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic [CNT_W-1:0] win_cnt,
  output logic             win_vld
);
  localparam int unsigned POS_W = dsd_pkg::index_width(WIN_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] tally_q;
  logic             win_close;

  function automatic logic [CNT_W-1:0] tally_add(input logic [CNT_W-1:0] t,
                                                  input logic b);
    return t + {{(CNT_W-1){1'b0}}, b};
  endfunction

  assign win_close = bit_vld && (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      tally_q <= '0;
      win_cnt <= '0;
      win_vld <= 1'b0;
    end else begin
      win_vld <= 1'b0;
      if (win_close) begin
        win_cnt <= tally_add(tally_q, bit_in);
        win_vld <= 1'b1;
        tally_q <= '0;
        pos_q   <= '0;
      end else if (bit_vld) begin
        tally_q <= tally_add(tally_q, bit_in);
        pos_q   <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsd_group_averager.sv
module dsd_group_averager #(
  parameter int unsigned AVG_LEN = 4,
  parameter int unsigned IN_W    = 5,
  parameter int unsigned SUM_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_cnt,
  input  logic             in_vld,
  output logic [SUM_W-1:0] grp_sum,
  output logic             grp_vld
);
  localparam int unsigned K_W = dsd_pkg::index_width(AVG_LEN);
  localparam logic [K_W-1:0] LAST_K = K_W'(AVG_LEN - 1);

  logic [K_W-1:0]   k_q;
  logic [SUM_W-1:0] acc_q;
  logic             grp_close;

  function automatic logic [SUM_W-1:0] widen_add(input logic [SUM_W-1:0] a,
                                                  input logic [IN_W-1:0] c);
    return a + {{(SUM_W-IN_W){1'b0}}, c};
  endfunction

  assign grp_close = in_vld && (k_q == LAST_K);

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q     <= '0;
      acc_q   <= '0;
      grp_sum <= '0;
      grp_vld <= 1'b0;
    end else begin
      grp_vld <= 1'b0;
      if (grp_close) begin
        grp_sum <= widen_add(acc_q, in_cnt);
        grp_vld <= 1'b1;
        acc_q   <= '0;
        k_q     <= '0;
      end else if (in_vld) begin
        acc_q <= widen_add(acc_q, in_cnt);
        k_q   <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsd_bitcount_decimator.sv
module dsd_bitcount_decimator #(
  parameter int unsigned WIN_LEN    = 16,
  parameter int unsigned AVG_LEN    = 4,
  parameter int unsigned OUT_W      = 16,
  parameter bit          LEFT_ALIGN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic [OUT_W-1:0] smp_data,
  output logic             smp_vld
);
  localparam int unsigned CNT_W = dsd_pkg::span_width(WIN_LEN);
  localparam int unsigned SUM_W = dsd_pkg::span_width(WIN_LEN * AVG_LEN);
  localparam int unsigned PAD_W = OUT_W - SUM_W;

  logic [CNT_W-1:0] win_cnt;
  logic             win_vld;
  logic [SUM_W-1:0] grp_sum;
  logic             grp_vld;

  dsd_window_counter #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .win_cnt(win_cnt), .win_vld(win_vld)
  );

  dsd_group_averager #(.AVG_LEN(AVG_LEN), .IN_W(CNT_W), .SUM_W(SUM_W)) u_avg (
    .clk(clk), .rst(rst), .in_cnt(win_cnt), .in_vld(win_vld),
    .grp_sum(grp_sum), .grp_vld(grp_vld)
  );

  generate
    if (LEFT_ALIGN) begin : g_left
      assign smp_data = {grp_sum, {PAD_W{1'b0}}};
    end else begin : g_right
      assign smp_data = {{PAD_W{1'b0}}, grp_sum};
    end
  endgenerate

  assign smp_vld = grp_vld;
endmodule

// File: rtl/dsd_bitcount_decimator_chk.sv
module dsd_bitcount_decimator_chk #(
  parameter int unsigned WIN_LEN    = 16,
  parameter int unsigned AVG_LEN    = 4,
  parameter int unsigned OUT_W      = 16,
  parameter bit          LEFT_ALIGN = 1'b0,
  parameter int unsigned CNT_W      = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic [CNT_W-1:0] win_cnt,
  input logic             win_vld,
  input logic [OUT_W-1:0] smp_data,
  input logic             smp_vld
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !smp_vld)
    else $error("reset did not silence output strobe");

  p_window_range_r2: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (win_cnt <= CNT_W'(WIN_LEN)))
    else $error("window count above window length");

  p_idle_no_window_r3: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> !win_vld)
    else $error("window closed without an accepted bit");

  p_sum_range_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !LEFT_ALIGN) |-> (smp_data <= OUT_W'(WIN_LEN * AVG_LEN)))
    else $error("sample above full scale");

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> !smp_vld)
    else $error("output strobe longer than one cycle");

  p_follows_window_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_vld) |-> $past(win_vld))
    else $error("output strobe without a window result before it");

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !$past(rst)) |-> $stable(smp_data))
    else $error("sample changed without a strobe");
endmodule

bind dsd_bitcount_decimator dsd_bitcount_decimator_chk #(
  .WIN_LEN(WIN_LEN), .AVG_LEN(AVG_LEN), .OUT_W(OUT_W),
  .LEFT_ALIGN(LEFT_ALIGN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .win_cnt(win_cnt),
  .win_vld(win_vld), .smp_data(smp_data), .smp_vld(smp_vld)
);

// File: tb/dsd_bitcount_decimator_test.sv
`timescale 1ns/1ps
module dsd_bitcount_decimator_test;
  localparam int WIN = 16;
  localparam int AVG = 4;
  localparam int OW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic [OW-1:0] smp_data;
  logic smp_vld;

  int vectors = 0;
  int misses  = 0;
  string req = "R1";

  // reference model state
  int ones = 0, nbits = 0, gsum = 0, ngrp = 0;
  int held = 0;
  bit p1_v = 0, p2_v = 0;
  int p1_d = 0, p2_d = 0;
  int pulses = 0;
  int last_seen = 0;

  dsd_bitcount_decimator uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .smp_data(smp_data), .smp_vld(smp_vld)
  );

  always #2 clk = ~clk;

  task automatic check(input string r, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  // One cycle: compare outputs due now, then drive the next inputs.
  task automatic cyc(input bit r, input bit v, input bit b);
    @(negedge clk);
    check(req, int'(smp_vld), int'(p2_v), "strobe");
    check(req, int'(smp_data), p2_v ? p2_d : held, "data");
    if (p2_v) begin held = p2_d; pulses++; last_seen = int'(smp_data); end
    p2_v = p1_v; p2_d = p1_d; p1_v = 0;
    rst = r; bit_vld = v; bit_in = b;
    if (r) begin
      ones = 0; nbits = 0; gsum = 0; ngrp = 0; held = 0;
      p1_v = 0; p2_v = 0;
    end else if (v) begin
      ones += b; nbits++;
      if (nbits == WIN) begin
        gsum += ones; ngrp++; ones = 0; nbits = 0;
        if (ngrp == AVG) begin
          p1_v = 1; p1_d = gsum; gsum = 0; ngrp = 0;
        end
      end
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit pat[8] = '{1,0,1,0,1,1,1,0};
    // R1: reset state
    req = "R1";
    for (int i = 0; i < 3; i++) cyc(1, 1, 1);
    cyc(0, 0, 0);
    @(negedge clk);
    check("R1", int'(smp_vld), 0, "strobe after reset");
    check("R1", int'(smp_data), 0, "data after reset");
    rst = 0; bit_vld = 0;

    // R8: all ones then all zeros
    req = "R8";
    pulses = 0;
    for (int i = 0; i < WIN*AVG; i++) cyc(0, 1, 1);
    flush();
    check("R8", last_seen, 64, "all-ones sample");
    for (int i = 0; i < WIN*AVG; i++) cyc(0, 1, 0);
    flush();
    check("R8", last_seen, 0, "all-zeros sample");
    check("R5", pulses, 2, "pulse count");

    // R9: repeated 8-bit pattern
    req = "R9";
    for (int i = 0; i < WIN*AVG; i++) cyc(0, 1, pat[i % 8]);
    flush();
    check("R9", last_seen, 40, "pattern sample");

    // R2/R4: pseudo-random bits back to back
    req = "R2/R4";
    for (int i = 0; i < WIN*AVG*6; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(0, 1, lfsr[0]);
    end
    flush();

    // R3: bits with valid low carry ones and must be ignored
    req = "R3";
    pulses = 0;
    for (int i = 0; i < WIN*AVG*3; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(0, 1, lfsr[3]);
      if (lfsr[1]) cyc(0, 0, 1);
      if (lfsr[2] && lfsr[5]) cyc(0, 0, 1);
    end
    flush();
    check("R3", pulses, 3, "pulses with gapped valid");

    // R6: long idle keeps the held value
    req = "R6";
    for (int i = 0; i < 40; i++) cyc(0, 0, 1);

    // R7: reset mid-window and mid-group
    req = "R7";
    for (int i = 0; i < WIN*2 + 5; i++) cyc(0, 1, 1);
    cyc(1, 0, 0);
    pulses = 0;
    for (int i = 0; i < WIN*AVG - 1; i++) cyc(0, 1, 0);
    flush();
    check("R7", pulses, 0, "no early sample after reset");
    cyc(0, 1, 0);
    flush();
    check("R7", pulses, 1, "sample after full group");
    check("R7", last_seen, 0, "post-reset sample excludes old ones");

    // R5: strobe timing under mixed traffic
    req = "R5";
    for (int i = 0; i < WIN*AVG*2; i++) cyc(0, 1, (i % 3) == 0);
    flush();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule